// File: doc/BRIEF.md
# Register-Programmed Watchdog Timer with Selectable Timeout Encoding

The block is a watchdog timer behind a small byte-wide register port. Software turns the countdown on and off with an enable bit and restarts it with a self-clearing ping bit. If software stops pinging, the count reaches its end. The block then drives a reset pulse of fixed length, turns itself off and records a sticky cause flag. That flag survives the system reset the pulse produced, so boot code can tell that a hang caused the restart.

A build parameter fixes how the timeout is encoded. Mode 1 holds a 4-bit power-of-two exponent of milliseconds. Mode 2 holds one byte of whole seconds. Mode 3 holds sixteen bits of whole seconds across two byte addresses. In modes 2 and 3 software can read the remaining whole seconds. A prescaler derives the millisecond or second unit from a parameterised system clock frequency. There are two synchronous active-high resets. `rst_por` clears everything. `rst` is the system reset that the watchdog output may drive, and it clears everything except the cause flag and the running reset pulse.

Register map, byte addresses:
- 0: control. Bit 0 is enable. Bit 1 is ping. Bit 7 is the cause flag.
- 1: timeout, low byte.
- 2: timeout, high byte.
- 3: time-left, low byte.
- 4: time-left, high byte.

Top module: `wdt_multimode`

## Requirements
- R1: After `rst_por`, the control register (address 0) reads 0x00, the time-left register (address 3) reads 0x00, and `wdt_rst_o` is low. Read data appears on `bus_rdata` one clock after `bus_rd` is sampled.
- R2: Writing control bit 0 = 1 while the block is disabled loads the countdown from the committed timeout and starts it. Writing bit 0 = 0 stops the countdown and freezes the time-left value. Setting bit 0 again reloads the countdown.
- R3: Writing 1 to control bit 1 (ping) reloads the countdown from the committed timeout. Bit 1 always reads back as 0.
- R4: If the block is not reloaded, `wdt_rst_o` rises exactly T × unit clock cycles after the capturing edge of the last reload, where T is the timeout in units. It stays high for RST_CYCLES cycles. At expiry, control bit 0 clears.
- R5: Expiry sets control bit 7. Bit 7 is kept through `rst`. Writing 1 to bit 7 clears it, and `rst_por` also clears it.
- R6: Mode 1:
  - Address 1 bits [3:0] hold an exponent n, and the period is 2^n ms. An n below 10 is treated as 10, so the minimum period is 1024 ms.
  - Bits [7:4] are plain storage and read back as written.
  - Address 3 always reads 0.
- R7: Mode 2: address 1 holds whole seconds, and a value of 0 counts as 1 second. Address 2 reads 0.
- R8: Mode 3:
  - A write to address 1 only stages the low byte. A write to address 2 commits {high, staged low} as one 16-bit value.
  - Before that commit, address 1 reads the previously committed low byte.
  - A committed value of 0 counts as 1 second.
- R9: In modes 2 and 3, address 3 returns the low byte of the remaining whole seconds. In mode 3, that same read captures the high byte, and address 4 returns the captured high byte.
- R10: A timeout write while the countdown runs does not change the current countdown. The new value is used only at the next ping or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high, clears all state |
| rst | input | 1 | System reset, synchronous, active high, keeps the cause flag and the pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after the read strobe |
| wdt_rst_o | output | 1 | Reset pulse driven on expiry |

## Verification
All three encodings are built side by side on a fast unit clock. Each expiry edge is checked one cycle before and at the predicted cycle, which separates a correct reload count from an off-by-one in the prescaler or the countdown.

The bench uses several timeout values:
- Exponents below and above the clamp, and zero in modes 2 and 3, tell the clamp apart from the raw encoding.
- A 256-second value read across a second boundary tells a captured high byte from a live one.
- A timeout written mid-count, followed by a ping, tells deferred use from immediate use.
- A low-byte-only write tells staging from a direct commit.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [2:0] {
        ADR_CTRL    = 3'd0,
        ADR_TMO_LO  = 3'd1,
        ADR_TMO_HI  = 3'd2,
        ADR_LEFT_LO = 3'd3,
        ADR_LEFT_HI = 3'd4
    } wdt_addr_e;

    localparam int BIT_EN    = 0;
    localparam int BIT_PING  = 1;
    localparam int BIT_CAUSE = 7;
    localparam int EXP_FLOOR = 10;
    localparam int CNT_W     = 16;

    typedef struct packed {
        logic             en;
        logic             reload;
        logic [CNT_W-1:0] load;
    } wdt_cmd_t;

    function automatic int unsigned wdt_tick_div(int unsigned mode, int unsigned hz);
        return (mode == 1) ? hz / 1000 : hz;
    endfunction

    function automatic logic [CNT_W-1:0] wdt_load_value(int unsigned mode, logic [15:0] raw);
        logic [3:0] e;
        logic [CNT_W-1:0] v;
        if (mode == 1) begin
            e = (raw[3:0] < 4'(EXP_FLOOR)) ? 4'(EXP_FLOOR) : raw[3:0];
            v = CNT_W'(1) << e;
        end else if (mode == 2) begin
            v = (raw[7:0] == 8'd0) ? CNT_W'(1) : CNT_W'(raw[7:0]);
        end else begin
            v = (raw == 16'd0) ? CNT_W'(1) : raw;
        end
        return v;
    endfunction

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int unsigned DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int W = $clog2(DIV + 1);

    logic [W-1:0] cnt_q;

    assign tick = run && !clr && (cnt_q == W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_por,
    input  logic             rst,
    input  wdt_cmd_t         cmd,
    input  logic             tick,
    output logic [CNT_W-1:0] left,
    output logic             expire,
    output logic             pulse
);
    localparam int PW = $clog2(RST_CYCLES + 1);

    logic [CNT_W-1:0] left_q;
    logic [PW-1:0]    pulse_q;

    assign expire = !rst && !rst_por && cmd.en && tick && !cmd.reload
                    && (left_q <= CNT_W'(1));
    assign left   = left_q;
    assign pulse  = (pulse_q != '0);

    always_ff @(posedge clk) begin
        if (rst_por || rst) begin
            left_q <= '0;
        end else if (cmd.reload) begin
            left_q <= cmd.load;
        end else if (expire) begin
            left_q <= '0;
        end else if (cmd.en && tick) begin
            left_q <= left_q - CNT_W'(1);
        end
    end

    // pulse counter is outside the system reset so the pulse it drives is not cut short
    always_ff @(posedge clk) begin
        if (rst_por) begin
            pulse_q <= '0;
        end else if (expire) begin
            pulse_q <= PW'(RST_CYCLES);
        end else if (pulse_q != '0) begin
            pulse_q <= pulse_q - PW'(1);
        end
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned MODE = 2
) (
    input  logic             clk,
    input  logic             rst_por,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             expire,
    input  logic [CNT_W-1:0] left,
    output logic [7:0]       bus_rdata,
    output wdt_cmd_t         cmd,
    output logic             cause
);
    logic        en_q;
    logic        cause_q;
    logic [15:0] tmo_q;
    logic [7:0]  stage_q;
    logic [7:0]  rdata_q;
    logic [7:0]  hi_snap;
    logic        wr_ctrl;
    logic        rd_left_lo;

    assign wr_ctrl    = bus_wr && (wdt_addr_e'(bus_addr) == ADR_CTRL);
    assign rd_left_lo = bus_rd && (wdt_addr_e'(bus_addr) == ADR_LEFT_LO);

    assign cmd.en     = en_q;
    assign cmd.reload = !rst && wr_ctrl &&
                        ((bus_wdata[BIT_EN] && !en_q) || bus_wdata[BIT_PING]);
    assign cmd.load   = wdt_load_value(MODE, tmo_q);
    assign cause      = cause_q;
    assign bus_rdata  = rdata_q;

    always_ff @(posedge clk) begin
        if (rst_por || rst) begin
            en_q <= 1'b0;
        end else if (expire) begin
            en_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q <= bus_wdata[BIT_EN];
        end
    end

    always_ff @(posedge clk) begin
        if (rst_por) begin
            cause_q <= 1'b0;
        end else if (expire) begin
            cause_q <= 1'b1;
        end else if (!rst && wr_ctrl && bus_wdata[BIT_CAUSE]) begin
            cause_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_por || rst) begin
            tmo_q   <= '0;
            stage_q <= '0;
        end else if (bus_wr) begin
            case (wdt_addr_e'(bus_addr))
                ADR_TMO_LO: begin
                    if (MODE == 3) stage_q <= bus_wdata;
                    else           tmo_q   <= {8'd0, bus_wdata};
                end
                ADR_TMO_HI: begin
                    if (MODE == 3) tmo_q <= {bus_wdata, stage_q};
                end
                default: ;
            endcase
        end
    end

    generate
        if (MODE == 3) begin : g_hi_snap
            logic [7:0] snap_q;
            always_ff @(posedge clk) begin
                if (rst_por || rst) snap_q <= '0;
                else if (rd_left_lo) snap_q <= left[15:8];
            end
            assign hi_snap = snap_q;
        end else begin : g_no_snap
            assign hi_snap = 8'd0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst_por || rst) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            case (wdt_addr_e'(bus_addr))
                ADR_CTRL:    rdata_q <= {cause_q, 6'd0, en_q};
                ADR_TMO_LO:  rdata_q <= tmo_q[7:0];
                ADR_TMO_HI:  rdata_q <= (MODE == 3) ? tmo_q[15:8] : 8'd0;
                ADR_LEFT_LO: rdata_q <= (MODE == 1) ? 8'd0 : left[7:0];
                ADR_LEFT_HI: rdata_q <= hi_snap;
                default:     rdata_q <= 8'd0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_multimode.sv
module wdt_multimode
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 100_000_000,
    parameter int unsigned MODE       = 2,
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_por,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       wdt_rst_o
);
    localparam int unsigned DIV = wdt_tick_div(MODE, CLK_HZ);

    wdt_cmd_t         cmd;
    logic             tick;
    logic             expire;
    logic             cause;
    logic [CNT_W-1:0] left;

    wdt_regs #(.MODE(MODE)) u_regs (
        .clk       (clk),
        .rst_por   (rst_por),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .expire    (expire),
        .left      (left),
        .bus_rdata (bus_rdata),
        .cmd       (cmd),
        .cause     (cause)
    );

    wdt_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst  (rst_por || rst),
        .run  (cmd.en),
        .clr  (cmd.reload),
        .tick (tick)
    );

    wdt_countdown #(.RST_CYCLES(RST_CYCLES)) u_cnt (
        .clk     (clk),
        .rst_por (rst_por),
        .rst     (rst),
        .cmd     (cmd),
        .tick    (tick),
        .left    (left),
        .expire  (expire),
        .pulse   (wdt_rst_o)
    );
endmodule

// File: rtl/wdt_multimode_chk.sv
module wdt_multimode_chk #(
    parameter int unsigned RST_CYCLES = 16
) (
    input logic        clk,
    input logic        rst_por,
    input logic        rst,
    input logic        en,
    input logic        reload,
    input logic        expire,
    input logic        cause,
    input logic [15:0] left,
    input logic        wdt_rst_o
);
    int unsigned hi_run;

    always_ff @(posedge clk) begin
        if (rst_por)        hi_run <= 0;
        else if (wdt_rst_o) hi_run <= hi_run + 1;
        else                hi_run <= 0;
    end

    a_r4_pulse_follows: assert property (@(posedge clk) disable iff (rst_por)
        expire |=> wdt_rst_o);

    a_r4_self_disable: assert property (@(posedge clk) disable iff (rst_por)
        expire |=> !en);

    a_r4_pulse_len: assert property (@(posedge clk) disable iff (rst_por)
        hi_run <= RST_CYCLES);

    a_r5_cause_on_expire: assert property (@(posedge clk) disable iff (rst_por)
        expire |=> cause);

    a_r5_cause_kept: assert property (@(posedge clk) disable iff (rst_por)
        (rst && cause) |=> cause);

    a_r9_left_step: assert property (@(posedge clk) disable iff (rst_por || rst)
        (en && !reload) |=> (left == $past(left) || left == $past(left) - 16'd1 || left == 16'd0));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst_por || rst)
        (!en && !reload) |=> $stable(left));
endmodule

bind wdt_multimode wdt_multimode_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk       (clk),
    .rst_por   (rst_por),
    .rst       (rst),
    .en        (cmd.en),
    .reload    (cmd.reload),
    .expire    (expire),
    .cause     (cause),
    .left      (left),
    .wdt_rst_o (wdt_rst_o)
);

// File: tb/test_wdt_multimode.sv
`timescale 1ns/1ps
module test_wdt_multimode;
    localparam int unsigned HZ   = 1000;
    localparam int unsigned RSTC = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_por, rst, bwr, brd;
    logic [2:0] badr;
    logic [7:0] bwd;
    int         sel;
    logic [7:0] rd1, rd2, rd3, rdm;
    logic       ro1, ro2, ro3, rom;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    wdt_multimode #(.CLK_HZ(HZ), .MODE(1), .RST_CYCLES(RSTC)) i_wdt_multimode_m1 (
        .clk(clk), .rst_por(rst_por), .rst(rst), .bus_wr(bwr && sel == 1), .bus_rd(brd && sel == 1),
        .bus_addr(badr), .bus_wdata(bwd), .bus_rdata(rd1), .wdt_rst_o(ro1));
    wdt_multimode #(.CLK_HZ(HZ), .MODE(2), .RST_CYCLES(RSTC)) i_wdt_multimode_m2 (
        .clk(clk), .rst_por(rst_por), .rst(rst), .bus_wr(bwr && sel == 2), .bus_rd(brd && sel == 2),
        .bus_addr(badr), .bus_wdata(bwd), .bus_rdata(rd2), .wdt_rst_o(ro2));
    wdt_multimode #(.CLK_HZ(HZ), .MODE(3), .RST_CYCLES(RSTC)) i_wdt_multimode (
        .clk(clk), .rst_por(rst_por), .rst(rst), .bus_wr(bwr && sel == 3), .bus_rd(brd && sel == 3),
        .bus_addr(badr), .bus_wdata(bwd), .bus_rdata(rd3), .wdt_rst_o(ro3));

    always_comb begin
        case (sel)
            1:       begin rdm = rd1; rom = ro1; end
            2:       begin rdm = rd2; rom = ro2; end
            default: begin rdm = rd3; rom = ro3; end
        endcase
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (mode %0d)", tag, act, exp, sel);
        end
    endtask

    // monitor: pops one expected byte per sampled read strobe
    always @(posedge clk) begin
        if (brd && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            #1;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {24'd0, rdm}, {24'd0, e});
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bwr = 1'b1; badr = a; bwd = d;
        @(negedge clk);
        bwr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, logic [7:0] e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        brd = 1'b1; badr = a;
        @(negedge clk);
        brd = 1'b0;
    endtask

    task automatic chk_out(string tag, logic e);
        check(tag, {31'd0, rom}, {31'd0, e});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        rst_por = 1'b1; rst = 1'b1; bwr = 1'b0; brd = 1'b0; badr = '0; bwd = '0; sel = 3;
        cyc(3);
        rst_por = 1'b0; rst = 1'b0;
        cyc(1);

        // R1 reset state on every mode
        for (int m = 1; m <= 3; m++) begin
            sel = m;
            rd(3'd0, 8'h00, "R1 ctrl");
            rd(3'd3, 8'h00, "R1 left");
            chk_out("R1 rst_o", 1'b0);
        end

        // ---------------- mode 1 ----------------
        sel = 1;
        wr(3'd1, 8'hA3);
        rd(3'd1, 8'hA3, "R6 spare bits");
        wr(3'd0, 8'h01);                 // exponent 3 clamps to 10
        cyc(1023); chk_out("R6 R4 before 1024", 1'b0);
        cyc(1);    chk_out("R6 R4 at 1024", 1'b1);
        cyc(3);    chk_out("R4 pulse last", 1'b1);
        cyc(1);    chk_out("R4 pulse end", 1'b0);
        rd(3'd0, 8'h80, "R4 R5 cause set, enable cleared");
        rd(3'd3, 8'h00, "R6 no time-left");
        wr(3'd0, 8'h80);
        rd(3'd0, 8'h00, "R5 w1c");
        wr(3'd1, 8'h0B);
        wr(3'd0, 8'h01);
        cyc(2047); chk_out("R6 before 2048", 1'b0);
        cyc(1);    chk_out("R6 at 2048", 1'b1);
        cyc(RSTC + 1);
        rst = 1'b1; cyc(1); rst = 1'b0;
        rd(3'd0, 8'h80, "R5 kept over rst");

        // ---------------- mode 2 ----------------
        sel = 2;
        wr(3'd1, 8'd3);
        wr(3'd0, 8'h01);
        rd(3'd3, 8'd3, "R9 left after start");
        wr(3'd1, 8'd9);                  // mid-count write
        cyc(1495);
        rd(3'd3, 8'd2, "R10 count unchanged");
        rd(3'd1, 8'd9, "R7 readback");
        wr(3'd0, 8'h03);                 // ping
        rd(3'd0, 8'h01, "R3 ping reads 0");
        rd(3'd3, 8'd9, "R3 R10 ping loads new value");
        wr(3'd1, 8'd2);
        wr(3'd0, 8'h00);
        cyc(10);
        rd(3'd3, 8'd9, "R2 frozen when off");
        wr(3'd0, 8'h01);
        cyc(1999); chk_out("R2 before 2000", 1'b0);
        cyc(1);    chk_out("R2 R4 at 2000", 1'b1);
        cyc(RSTC);
        wr(3'd0, 8'h80);
        wr(3'd1, 8'd0);
        wr(3'd0, 8'h01);
        cyc(999); chk_out("R7 zero before 1000", 1'b0);
        cyc(1);   chk_out("R7 zero clamps to 1s", 1'b1);
        cyc(RSTC);
        rd(3'd2, 8'h00, "R7 high byte absent");

        // ---------------- mode 3 ----------------
        sel = 3;
        wr(3'd1, 8'h02);
        wr(3'd2, 8'h00);
        rd(3'd1, 8'h02, "R8 commit lo");
        wr(3'd1, 8'h05);
        rd(3'd1, 8'h02, "R8 staged not live");
        wr(3'd0, 8'h01);
        rd(3'd3, 8'h02, "R8 count from committed");
        cyc(1998); chk_out("R8 before 2000", 1'b0);
        cyc(1);    chk_out("R8 at 2000", 1'b1);
        cyc(RSTC);
        wr(3'd0, 8'h80);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h01);                 // 256 s
        wr(3'd0, 8'h01);
        rd(3'd3, 8'h00, "R9 lo at start");
        cyc(1100);
        rd(3'd4, 8'h01, "R9 high byte captured");
        rd(3'd3, 8'hFF, "R9 lo after 1s");
        rd(3'd4, 8'h00, "R9 new capture");
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h01);
        cyc(999); chk_out("R8 zero before 1000", 1'b0);
        cyc(1);   chk_out("R8 zero clamps to 1s", 1'b1);
        cyc(RSTC + 1);
        rd(3'd0, 8'h80, "R5 cause after expiry");
        rst_por = 1'b1; cyc(1); rst_por = 1'b0;
        rd(3'd0, 8'h00, "R5 cleared by por");
        chk_out("R1 rst_o after por", 1'b0);

        cyc(3);
        done = 1;
        summary();
    end
endmodule